// File: doc/BRIEF.md
# Attack Response and Recovery Controller

This block sits beside a set of bus firewalls and turns their attack reports into protection decisions. Each firewall guards one IP and raises a one-cycle flag when it blocks a suspicious transfer. The controller records which firewalls fired and raises a level interrupt to a trusted processor. It also moves the guarded IP into a degraded protection mode. IPs configured as critical are isolated in error-code mode, where a fixed value replaces their outgoing data. Other IPs are dropped to a read-only mode, in which reads still pass and writes are blocked.

A degraded IP comes back to its normal mode on its own. This happens once a programmable number of attack-free cycles has passed. A fresh attack during that window starts the count again. Each firewall also gets a reconfiguration-enable bit. The bit stays set from its attack until the processor acknowledges the interrupt, so the firewall knows its policy store may be rewritten in that period.

Top module: `arc_attack_ctrl`

## Requirements
- R1: After reset every IP is in normal mode, irq_o is low and recfg_en_o is all zero. The mode codes are 2'b00 normal, 2'b01 read-only and 2'b10 error-code, and code 2'b11 never appears. IP i's code sits at mode_o[2i+1:2i].
- R2: An attack flag on an IP whose critical_i bit is 1 puts that IP in error-code mode from the next cycle.
- R3: An attack flag on an IP whose critical_i bit is 0 puts that IP in read-only mode from the next cycle, unless the IP is already in error-code mode.
- R4: A degraded IP returns to normal mode after exactly L clock edges without an attack on it, counted after the edge that sampled the last attack. L is the value of quiet_len_i at that attack. A value of 0 acts as 1.
- R5: An attack on an IP that is already degraded reloads its window from quiet_len_i. A change of quiet_len_i with no attack has no effect on a window that is already running.
- R6: An attack never lowers the severity of a mode. An error-code IP stays in error-code mode when attacked with critical_i low. A read-only IP attacked with critical_i high moves to error-code mode.
- R7: irq_o rises the cycle after any attack flag. It stays high until irq_clr_i is sampled. If a clear and an attack are sampled at the same edge, irq_o stays high.
- R8: recfg_en_o[i] sets the cycle after an attack on firewall i and holds until irq_clr_i. A clear drops every bit, except the bits of firewalls that are attacked at the same edge.
- R9: Each IP's mode and window depend only on its own attack flag and critical bit. An attack on one IP leaves every other IP's mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attack_i | input | NUM_FW | Attack flag per firewall/IP |
| critical_i | input | NUM_FW | 1 marks the IP as critical |
| quiet_len_i | input | CNT_W | Attack-free cycles needed before restore |
| irq_clr_i | input | 1 | Interrupt acknowledge; also clears reconfiguration enables |
| mode_o | output | 2*NUM_FW | Protection mode per IP, two bits each |
| recfg_en_o | output | NUM_FW | Reconfiguration enable per firewall |
| irq_o | output | 1 | Level interrupt to the trusted processor |

## Verification
A corrupted window counter shows up at mode_o as a restore that comes one or more cycles early or late. The bench samples the mode on the cycle just before the expected restore and on the cycle of it, so an off-by-one error is caught at once. A wrong severity merge shows as the wrong mode code on the cycle after the attack. A lost pending bit shows on recfg_en_o or irq_o one cycle after the flag or the clear. A channel that couples to its neighbours shows as a mode change on an IP that was never attacked.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_RDONLY  = 2'b01,
    MODE_ERRCODE = 2'b10
  } prot_mode_e;
endpackage

// File: rtl/arc_ip_channel.sv
// One protected IP: severity-merged mode plus quiet-window countdown.
module arc_ip_channel
  import arc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attack_i,
  input  logic             critical_i,
  input  logic [CNT_W-1:0] quiet_len_i,
  output logic [1:0]       mode_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  prot_mode_e       mode_q, mode_nx, target;
  logic [CNT_W-1:0] cnt_q, cnt_nx, len_eff;
  logic             upd_en;

  always_comb begin
    target  = critical_i ? MODE_ERRCODE : MODE_RDONLY;
    len_eff = (quiet_len_i == '0) ? ONE : quiet_len_i;
    mode_nx = mode_q;
    cnt_nx  = cnt_q;
    upd_en  = attack_i || (mode_q != MODE_NORMAL);
    if (attack_i) begin
      // severity never drops on an attack
      mode_nx = (mode_q == MODE_ERRCODE) ? MODE_ERRCODE : target;
      cnt_nx  = len_eff;
    end else if (mode_q != MODE_NORMAL) begin
      if (cnt_q <= ONE) begin
        mode_nx = MODE_NORMAL;
        cnt_nx  = '0;
      end else begin
        cnt_nx = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      cnt_q  <= '0;
    end else if (upd_en) begin
      mode_q <= mode_nx;
      cnt_q  <= cnt_nx;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/arc_irq_ctrl.sv
// Pending-attack bitmap (drives reconfiguration enables) and level interrupt.
module arc_irq_ctrl #(
  parameter int NUM_FW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FW-1:0] attack_i,
  input  logic              irq_clr_i,
  output logic [NUM_FW-1:0] recfg_en_o,
  output logic              irq_o
);
  logic [NUM_FW-1:0] pend_q, pend_nx;
  logic              irq_q, irq_nx, any_atk, upd_en;

  always_comb begin
    any_atk = |attack_i;
    upd_en  = any_atk || irq_clr_i;
    pend_nx = irq_clr_i ? attack_i : (pend_q | attack_i);
    irq_nx  = any_atk || (irq_q && !irq_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_nx;
      irq_q  <= irq_nx;
    end
  end

  assign recfg_en_o = pend_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/arc_attack_ctrl.sv
module arc_attack_ctrl #(
  parameter int NUM_FW = 8,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_FW-1:0]   attack_i,
  input  logic [NUM_FW-1:0]   critical_i,
  input  logic [CNT_W-1:0]    quiet_len_i,
  input  logic                irq_clr_i,
  output logic [2*NUM_FW-1:0] mode_o,
  output logic [NUM_FW-1:0]   recfg_en_o,
  output logic                irq_o
);
  localparam int MODE_W = 2 * NUM_FW;

  generate
    if (NUM_FW < 1 || NUM_FW > 16) begin : g_bad_cfg
      initial $error("NUM_FW must be in 1..16");
    end
  endgenerate

  logic [MODE_W-1:0] mode_w;

  for (genvar g = 0; g < NUM_FW; g++) begin : g_chan
    arc_ip_channel #(.CNT_W(CNT_W)) chan_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .attack_i   (attack_i[g]),
      .critical_i (critical_i[g]),
      .quiet_len_i(quiet_len_i),
      .mode_o     (mode_w[2*g +: 2])
    );
  end

  arc_irq_ctrl #(.NUM_FW(NUM_FW)) irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .attack_i  (attack_i),
    .irq_clr_i (irq_clr_i),
    .recfg_en_o(recfg_en_o),
    .irq_o     (irq_o)
  );

  assign mode_o = mode_w;
endmodule

// File: rtl/arc_attack_ctrl_chk.sv
module arc_attack_ctrl_chk #(
  parameter int NUM_FW = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_FW-1:0]   attack_i,
  input logic [NUM_FW-1:0]   critical_i,
  input logic                irq_clr_i,
  input logic [2*NUM_FW-1:0] mode_o,
  input logic [NUM_FW-1:0]   recfg_en_o,
  input logic                irq_o
);
  assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|attack_i) |=> irq_o);
  assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o);

  for (genvar i = 0; i < NUM_FW; i++) begin : g_ip
    assert_legal_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o[2*i +: 2] != 2'b11);
    assert_crit_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (attack_i[i] && critical_i[i]) |=> mode_o[2*i +: 2] == 2'b10);
    assert_nc_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (attack_i[i] && !critical_i[i] && mode_o[2*i +: 2] != 2'b10)
        |=> mode_o[2*i +: 2] == 2'b01);
    assert_no_downgrade_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (attack_i[i] && mode_o[2*i +: 2] == 2'b10) |=> mode_o[2*i +: 2] == 2'b10);
    assert_restore_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o[2*i +: 2] != 2'b00 && attack_i[i]) |=> mode_o[2*i +: 2] != 2'b00);
    assert_recfg_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      attack_i[i] |=> recfg_en_o[i]);
    assert_recfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (recfg_en_o[i] && !irq_clr_i) |=> recfg_en_o[i]);
  end
endmodule

bind arc_attack_ctrl arc_attack_ctrl_chk #(.NUM_FW(NUM_FW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .attack_i  (attack_i),
  .critical_i(critical_i),
  .irq_clr_i (irq_clr_i),
  .mode_o    (mode_o),
  .recfg_en_o(recfg_en_o),
  .irq_o     (irq_o)
);

// File: tb/arc_attack_ctrl_tb_top.sv
`timescale 1ns/1ps
module arc_attack_ctrl_tb_top;
  localparam int NFW = 8;
  localparam int CW  = 16;

  logic            clk;
  logic            rst_n;
  logic [NFW-1:0]  attack;
  logic [NFW-1:0]  critical;
  logic [CW-1:0]   qlen;
  logic            clr;
  logic [2*NFW-1:0] mode;
  logic [NFW-1:0]  recfg;
  logic            irq;

  int n_chk;
  int n_fail;
  bit done;

  arc_attack_ctrl #(.NUM_FW(NFW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .attack_i(attack), .critical_i(critical),
    .quiet_len_i(qlen), .irq_clr_i(clr), .mode_o(mode),
    .recfg_en_o(recfg), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [1:0] md(int i);
    return mode[2*i +: 2];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    attack = '0; critical = '0; clr = 1'b0; qlen = CW'(5);
    rst_n = 1'b0;
    wait_cyc(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive flags for one cycle; returns at the negedge after the sampling edge
  task automatic pulse(logic [NFW-1:0] m);
    attack = m;
    @(negedge clk);
    attack = '0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "mode after reset", 32'(mode), 32'h0);
    check("R1", "irq after reset", 32'(irq), 32'h0);
    check("R1", "recfg after reset", 32'(recfg), 32'h0);
  endtask

  task automatic t_critical();
    do_reset();
    critical = 8'h04;
    pulse(8'h04);
    check("R2", "critical IP2 mode", 32'(md(2)), 32'h2);
    check("R9", "other modes untouched", 32'(mode & ~16'h0030), 32'h0);
  endtask

  task automatic t_noncritical();
    do_reset();
    pulse(8'h01);
    check("R3", "non-critical IP0 mode", 32'(md(0)), 32'h1);
    check("R9", "IP1 untouched", 32'(md(1)), 32'h0);
  endtask

  task automatic t_window();
    do_reset();
    qlen = CW'(5);
    pulse(8'h08);
    wait_cyc(4);
    check("R4", "still degraded at L-1", 32'(md(3)), 32'h1);
    wait_cyc(1);
    check("R4", "restored at L", 32'(md(3)), 32'h0);
  endtask

  task automatic t_zero_window();
    do_reset();
    qlen = '0;
    critical = 8'h10;
    pulse(8'h10);
    check("R4", "zero window degraded", 32'(md(4)), 32'h2);
    wait_cyc(1);
    check("R4", "zero window acts as 1", 32'(md(4)), 32'h0);
  endtask

  task automatic t_restart();
    do_reset();
    qlen = CW'(5);
    pulse(8'h02);
    wait_cyc(3);
    pulse(8'h02);
    wait_cyc(4);
    check("R5", "window restarted, still degraded", 32'(md(1)), 32'h1);
    wait_cyc(1);
    check("R5", "restored after reload", 32'(md(1)), 32'h0);
  endtask

  task automatic t_len_change();
    do_reset();
    qlen = CW'(5);
    pulse(8'h20);
    qlen = CW'(2);
    wait_cyc(3);
    check("R5", "qlen change ignored mid-window", 32'(md(5)), 32'h1);
    wait_cyc(1);
    wait_cyc(1);
    check("R5", "restore at original length", 32'(md(5)), 32'h0);
  endtask

  task automatic t_severity();
    do_reset();
    critical = 8'h40;
    pulse(8'h40);
    critical = 8'h00;
    pulse(8'h40);
    check("R6", "error-code kept on non-critical attack", 32'(md(6)), 32'h2);
    pulse(8'h80);
    critical = 8'h80;
    pulse(8'h80);
    check("R6", "read-only escalates to error-code", 32'(md(7)), 32'h2);
  endtask

  task automatic t_irq();
    do_reset();
    pulse(8'h01);
    check("R7", "irq raised", 32'(irq), 32'h1);
    wait_cyc(10);
    check("R7", "irq held", 32'(irq), 32'h1);
    check("R8", "recfg bit held", 32'(recfg), 32'h01);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R7", "irq cleared", 32'(irq), 32'h0);
    check("R8", "recfg cleared", 32'(recfg), 32'h0);
  endtask

  task automatic t_clr_collide();
    do_reset();
    pulse(8'h03);
    check("R8", "bitmap two firewalls", 32'(recfg), 32'h03);
    clr = 1'b1;
    attack = 8'h10;
    @(negedge clk);
    clr = 1'b0;
    attack = '0;
    check("R7", "set wins over clear", 32'(irq), 32'h1);
    check("R8", "only colliding bit kept", 32'(recfg), 32'h10);
  endtask

  task automatic t_independent();
    do_reset();
    qlen = CW'(3);
    critical = 8'h01;
    pulse(8'h01);
    wait_cyc(1);
    qlen = CW'(6);
    pulse(8'h02);
    check("R9", "IP0 error, IP1 read-only", 32'(mode[3:0]), 32'h6);
    wait_cyc(1);
    check("R9", "IP0 restored, IP1 kept", 32'(mode[3:0]), 32'h4);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; attack = '0; critical = '0; qlen = '0; clr = 1'b0;
    t_reset();
    t_critical();
    t_noncritical();
    t_window();
    t_zero_window();
    t_restart();
    t_len_change();
    t_severity();
    t_irq();
    t_clr_collide();
    t_independent();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200us;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule